// File: doc/BRIEF.md
# Ethernet Frame Padder and FCS Inserter with Receive FCS Stripper

This block is the byte-wide framing stage of a gigabit Ethernet MAC running in a single 125 MHz domain. On the transmit side it accepts a frame over a byte-wide AXI-Stream input. The frame starts at the destination MAC address and carries neither preamble nor checksum. The block drives the frame onto a GMII-style byte output. It puts a preamble and start delimiter in front of the frame and extends short frames with zero bytes. It then appends the 32-bit frame check sequence, and it keeps a minimum idle gap before the next frame.

On the receive side it hunts for the start delimiter on the GMII-style input and delivers the frame body on an AXI-Stream output that has no back-pressure. It holds back the last four bytes so that the checksum never reaches the user, and it compares them with a CRC computed over the delivered bytes. Zero padding stays in the delivered data. A checksum mismatch is reported on the user flag that comes with the last byte.

Top module: `eth_pad_fcs`

## Requirements
- R1: Every transmitted frame starts with seven bytes of 0x55 followed by one byte of 0xD5, with gmii_tx_en high from the first preamble byte onward.
- R2: Each frame byte accepted on the input appears on gmii_txd in the same order, right after the start delimiter, and gmii_tx_en stays high without a break until the last checksum byte.
- R3: A frame of fewer than 60 input bytes (the minimum is 14) is extended with 0x00 bytes up to 60 bytes before the checksum.
- R4: A frame of 60 to 1514 input bytes is sent with no bytes added or removed before the checksum.
- R5: After the data, which includes any padding, four checksum bytes follow. They hold the bitwise complement of the reflected CRC-32 (polynomial 0x04C11DB7, reflected constant 0xEDB88320, start value all ones), least-significant byte first.
- R6: Between the end of one frame and the first preamble byte of the next, gmii_tx_en is low for at least 12 cycles.
- R7: s_tready is high only while the block takes frame bytes. Once the first byte is offered, the source holds s_tvalid high until tlast is accepted.
- R8: On receive, the preamble, the start delimiter and the final four bytes are removed. All other bytes, padding included, are delivered in order, one per m_tvalid cycle, and m_tlast marks the last one.
- R9: m_tuser is 1 on the last byte of a received frame when its last four bytes do not equal the complemented CRC-32 of the bytes before them, and 0 otherwise. m_tuser is 0 on every byte other than the last.
- R10: After reset, gmii_tx_en, s_tready and m_tvalid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | 8 | Transmit frame byte |
| s_tvalid | input | 1 | Transmit byte valid |
| s_tlast | input | 1 | Last byte of the transmit frame |
| s_tready | output | 1 | Block takes the transmit byte this cycle |
| gmii_txd | output | 8 | Transmit line byte |
| gmii_tx_en | output | 1 | Transmit line byte valid |
| gmii_rxd | input | 8 | Receive line byte |
| gmii_rx_dv | input | 1 | Receive line byte valid |
| m_tdata | output | 8 | Received frame byte |
| m_tvalid | output | 1 | Received byte valid; there is no ready |
| m_tlast | output | 1 | Last byte of the received frame |
| m_tuser | output | 1 | Checksum mismatch, valid with m_tlast |

## Verification
The assertions check on every cycle the things that hold at any instant. A line burst always opens with a preamble byte, and the idle run before a burst is never shorter than the gap. No checksum starts before 60 data bytes have gone out. The source never lets s_tvalid drop while bytes are being taken. The error flag appears only on a last byte, and no byte follows a last byte in the next cycle. Byte-for-byte content needs the bench's scenarios. These cover the exact padding length at 14, 59, 60 and 61 bytes, the checksum value, the order of the checksum bytes, the delivery of padding through the receive path, and the error flag for a corrupted checksum.

// File: rtl/eth_fcs_pkg.sv
package eth_fcs_pkg;

  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;
  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam int          FCS_BYTES     = 4;

  typedef enum logic [2:0] {
    TX_IDLE, TX_PRE, TX_DATA, TX_PAD, TX_FCS, TX_GAP
  } tx_state_t;

  typedef enum logic {
    RX_HUNT, RX_BODY
  } rx_state_t;

  // One byte of the reflected CRC-32, LSB of the byte first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

  // Byte idx (0 = least significant) of the complemented CRC register.
  function automatic logic [7:0] fcs_byte(input logic [31:0] c, input logic [1:0] idx);
    logic [31:0] f;
    f = (~c) >> {idx, 3'b000};
    return f[7:0];
  endfunction

endpackage

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_fcs_pkg::*;
#(
  parameter int PRE_BYTES = 7,
  parameter int MIN_DATA  = 60,
  parameter int MAX_FRAME = 1514,
  parameter int IFG_BYTES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] s_tdata,
  input  logic       s_tvalid,
  input  logic       s_tlast,
  output logic       s_tready,
  output logic [7:0] txd,
  output logic       tx_en
);

  localparam int CW = $clog2(MAX_FRAME + IFG_BYTES + PRE_BYTES + 2);
  localparam logic [CW-1:0] PRE_LAST = CW'(PRE_BYTES);
  localparam logic [CW-1:0] MIN_LEN  = CW'(MIN_DATA);
  localparam logic [CW-1:0] GAP_LAST = CW'(IFG_BYTES - 1);
  localparam logic [CW-1:0] IFG_SAT  = CW'(IFG_BYTES);

  tx_state_t     state;
  logic [CW-1:0] cnt;
  logic [31:0]   crc;
  logic [1:0]    fidx;

  // Named events for the assertions
  logic          byte_take;
  logic [CW-1:0] cnt_next;
  logic          fcs_first;
  logic [CW-1:0] idle_run;

  assign s_tready  = (state == TX_DATA);
  assign byte_take = s_tvalid && s_tready;
  assign cnt_next  = cnt + 1'b1;
  assign fcs_first = (state == TX_FCS) && (fidx == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      cnt   <= '0;
      crc   <= CRC_SEED;
      fidx  <= '0;
      txd   <= '0;
      tx_en <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          tx_en <= 1'b0;
          txd   <= '0;
          if (s_tvalid) begin
            state <= TX_PRE;
            cnt   <= '0;
          end
        end
        TX_PRE: begin
          tx_en <= 1'b1;
          txd   <= (cnt == PRE_LAST) ? SFD_BYTE : PRE_BYTE;
          if (cnt == PRE_LAST) begin
            state <= TX_DATA;
            cnt   <= '0;
            crc   <= CRC_SEED;
          end else begin
            cnt <= cnt_next;
          end
        end
        TX_DATA: begin
          if (byte_take) begin
            tx_en <= 1'b1;
            txd   <= s_tdata;
            crc   <= crc32_step(crc, s_tdata);
            cnt   <= cnt_next;
            if (s_tlast) begin
              fidx <= '0;
              state <= (cnt_next < MIN_LEN) ? TX_PAD : TX_FCS;
            end
          end else begin
            tx_en <= 1'b0;
          end
        end
        TX_PAD: begin
          tx_en <= 1'b1;
          txd   <= 8'h00;
          crc   <= crc32_step(crc, 8'h00);
          cnt   <= cnt_next;
          if (cnt_next == MIN_LEN) begin
            state <= TX_FCS;
            fidx  <= '0;
          end
        end
        TX_FCS: begin
          tx_en <= 1'b1;
          txd   <= fcs_byte(crc, fidx);
          fidx  <= fidx + 2'd1;
          if (fidx == 2'd3) begin
            state <= TX_GAP;
            cnt   <= '0;
          end
        end
        default: begin
          tx_en <= 1'b0;
          txd   <= '0;
          cnt   <= cnt_next;
          if (cnt == GAP_LAST) state <= TX_IDLE;
        end
      endcase
    end
  end

  // Length of the idle run on the line, saturating at the gap size
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_run <= IFG_SAT;
    end else if (tx_en) begin
      idle_run <= '0;
    end else if (idle_run < IFG_SAT) begin
      idle_run <= idle_run + 1'b1;
    end
  end

  // R1
  preamble_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (txd == PRE_BYTE));

  // R6
  ifg_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (idle_run >= IFG_SAT));

  // R3
  pad_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_first |-> (cnt >= MIN_LEN));

  // R7
  tx_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_tready |-> s_tvalid);

endmodule

// File: rtl/eth_rx_fcs_strip.sv
module eth_rx_fcs_strip
  import eth_fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rxd,
  input  logic       rx_dv,
  output logic [7:0] m_tdata,
  output logic       m_tvalid,
  output logic       m_tlast,
  output logic       m_tuser
);

  localparam int DEPTH = FCS_BYTES + 1;
  localparam int FW    = $clog2(DEPTH + 1);
  localparam logic [FW-1:0] FULL = FW'(DEPTH);

  rx_state_t   state;
  logic [7:0]  sh [DEPTH];
  logic [FW-1:0] fill;
  logic [31:0] crc;

  // Named events for the assertions
  logic [31:0] crc_last;
  logic [31:0] fcs_rx;
  logic        fcs_bad;
  logic        emit;

  assign crc_last = crc32_step(crc, sh[DEPTH-1]);
  assign fcs_bad  = (~crc_last) != fcs_rx;
  assign emit     = (state == RX_BODY) && (fill == FULL);

  // Oldest held checksum byte is the least significant one
  always_comb begin
    fcs_rx = '0;
    for (int k = 0; k < FCS_BYTES; k++) begin
      fcs_rx[8*k +: 8] = sh[FCS_BYTES-1-k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_HUNT;
      fill     <= '0;
      crc      <= CRC_SEED;
      m_tdata  <= '0;
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
      m_tuser  <= 1'b0;
      for (int k = 0; k < DEPTH; k++) sh[k] <= '0;
    end else begin
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
      m_tuser  <= 1'b0;
      if (state == RX_HUNT) begin
        if (rx_dv && rxd == SFD_BYTE) begin
          state <= RX_BODY;
          fill  <= '0;
          crc   <= CRC_SEED;
        end
      end else if (rx_dv) begin
        sh[0] <= rxd;
        for (int k = 1; k < DEPTH; k++) sh[k] <= sh[k-1];
        if (emit) begin
          m_tvalid <= 1'b1;
          m_tdata  <= sh[DEPTH-1];
          crc      <= crc_last;
        end else begin
          fill <= fill + 1'b1;
        end
      end else begin
        state <= RX_HUNT;
        if (emit) begin
          m_tvalid <= 1'b1;
          m_tdata  <= sh[DEPTH-1];
          m_tlast  <= 1'b1;
          m_tuser  <= fcs_bad;
        end
      end
    end
  end

  // R9
  tuser_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tuser |-> (m_tvalid && m_tlast));

  // R8
  last_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |=> !m_tvalid);

  // R8
  body_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> $past(state == RX_BODY));

endmodule

// File: rtl/eth_pad_fcs.sv
module eth_pad_fcs #(
  parameter int PRE_BYTES = 7,
  parameter int MIN_DATA  = 60,
  parameter int MAX_FRAME = 1514,
  parameter int IFG_BYTES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] s_tdata,
  input  logic       s_tvalid,
  input  logic       s_tlast,
  output logic       s_tready,
  output logic [7:0] gmii_txd,
  output logic       gmii_tx_en,
  input  logic [7:0] gmii_rxd,
  input  logic       gmii_rx_dv,
  output logic [7:0] m_tdata,
  output logic       m_tvalid,
  output logic       m_tlast,
  output logic       m_tuser
);

  eth_tx_framer #(
    .PRE_BYTES(PRE_BYTES),
    .MIN_DATA (MIN_DATA),
    .MAX_FRAME(MAX_FRAME),
    .IFG_BYTES(IFG_BYTES)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_tdata (s_tdata),
    .s_tvalid(s_tvalid),
    .s_tlast (s_tlast),
    .s_tready(s_tready),
    .txd     (gmii_txd),
    .tx_en   (gmii_tx_en)
  );

  eth_rx_fcs_strip u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rxd     (gmii_rxd),
    .rx_dv   (gmii_rx_dv),
    .m_tdata (m_tdata),
    .m_tvalid(m_tvalid),
    .m_tlast (m_tlast),
    .m_tuser (m_tuser)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!gmii_tx_en && !s_tready && !m_tvalid));

endmodule

// File: tb/sim_eth_pad_fcs.sv
module sim_eth_pad_fcs;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [7:0] s_tdata;
  logic       s_tvalid, s_tlast, s_tready;
  logic [7:0] gmii_txd;
  logic       gmii_tx_en;
  logic [7:0] m_tdata;
  logic       m_tvalid, m_tlast, m_tuser;

  logic       inj_on;
  logic [7:0] inj_d;
  logic       inj_dv;
  logic [7:0] rxd_mux;
  logic       rxdv_mux;
  assign rxd_mux  = inj_on ? inj_d  : gmii_txd;
  assign rxdv_mux = inj_on ? inj_dv : gmii_tx_en;

  eth_pad_fcs u0 (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .gmii_txd(gmii_txd), .gmii_tx_en(gmii_tx_en),
    .gmii_rxd(rxd_mux), .gmii_rx_dv(rxdv_mux),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tuser(m_tuser)
  );

  int n_chk = 0;
  int n_err = 0;

  typedef struct { logic [7:0] d; int req; bit marker; } tx_item_t;
  typedef struct { logic [7:0] d; bit last; bit user; int req; } rx_item_t;
  tx_item_t tx_q[$];
  rx_item_t rx_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Independent checksum: shift-register form, one bit at a time
  function automatic logic [31:0] ref_fcs(input logic [7:0] q[$]);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    foreach (q[i]) begin
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ q[i][b];
        c  = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return ~c;
  endfunction

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'((seed * 13 + i * 7 + 1) & 255);
  endfunction

  // Driver: offers a frame, pushes the expected line and receive bytes
  task automatic send_frame(input int len, input int seed);
    logic [7:0] body[$];
    logic [31:0] f;
    int i;
    int padded;
    for (int k = 0; k < len; k++) body.push_back(pay(seed, k));
    padded = (len < 60) ? 60 : len;
    for (int k = len; k < padded; k++) body.push_back(8'h00);
    f = ref_fcs(body);
    for (int k = 0; k < 7; k++) tx_q.push_back('{8'h55, 1, 0});     // R1
    tx_q.push_back('{8'hD5, 1, 0});                                  // R1
    for (int k = 0; k < padded; k++) begin
      tx_q.push_back('{body[k], (k < len) ? ((len >= 60) ? 4 : 2) : 3, 0});
      rx_q.push_back('{body[k], k == padded - 1, 0, (k < len) ? 8 : 3});
    end
    for (int k = 0; k < 4; k++) tx_q.push_back('{f[8*k +: 8], 5, 0}); // R5
    tx_q.push_back('{8'h00, 2, 1});                                  // end of burst, R2
    i = 0;
    @(negedge clk);
    s_tvalid = 1'b1; s_tdata = body[0]; s_tlast = (len == 1);
    while (i < len) begin
      bit hs;
      hs = s_tready;
      @(negedge clk);
      if (hs) begin
        i++;
        if (i < len) begin
          s_tdata = body[i];
          s_tlast = (i == len - 1);
        end else begin
          s_tvalid = 1'b0;
          s_tlast  = 1'b0;
        end
      end
    end
  endtask

  // Drives a raw frame onto the receive input, checksum optionally corrupted
  task automatic inject(input int len, input int seed, input bit corrupt);
    logic [7:0] body[$];
    logic [31:0] f;
    for (int k = 0; k < len; k++) body.push_back(pay(seed, k));
    f = ref_fcs(body) ^ (corrupt ? 32'h0000_0001 : 32'h0);
    for (int k = 0; k < len; k++) rx_q.push_back('{body[k], k == len - 1, (k == len - 1) && corrupt, 9});
    @(negedge clk);
    inj_on = 1'b1;
    for (int k = 0; k < 8; k++) begin
      inj_dv = 1'b1; inj_d = (k == 7) ? 8'hD5 : 8'h55;
      @(negedge clk);
    end
    for (int k = 0; k < len; k++) begin
      inj_d = body[k];
      @(negedge clk);
    end
    for (int k = 0; k < 4; k++) begin
      inj_d = f[8*k +: 8];
      @(negedge clk);
    end
    inj_dv = 1'b0; inj_d = 8'h00;
    repeat (4) @(negedge clk);
    inj_on = 1'b0;
  endtask

  // Line monitor
  bit prev_en = 1'b0;
  bit seen    = 1'b0;
  int gap     = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (gmii_tx_en) begin
        tx_item_t it;
        if (!prev_en && seen) chk(gap >= 12, "R6 idle gap", gap, 12);
        if (tx_q.size() == 0) chk(0, "R2 unexpected line byte", gmii_txd, 0);
        else begin
          it = tx_q.pop_front();
          if (it.marker) chk(0, "R3/R4 burst too long", gmii_txd, 0);
          else chk(gmii_txd == it.d, $sformatf("R%0d line byte", it.req), gmii_txd, it.d);
        end
        gap = 0;
      end else begin
        if (prev_en) begin
          seen = 1'b1;
          if (tx_q.size() != 0 && tx_q[0].marker) begin
            void'(tx_q.pop_front());
            chk(1, "R2 burst end", 0, 0);
          end else chk(0, "R2 burst ended early", 0, 1);
        end
        gap++;
      end
      prev_en = gmii_tx_en;
    end
  end

  // Receive monitor (no back-pressure: every valid cycle is consumed)
  always @(negedge clk) begin
    if (rst_n && m_tvalid) begin
      rx_item_t it;
      if (rx_q.size() == 0) chk(0, "R8 unexpected receive byte", m_tdata, 0);
      else begin
        it = rx_q.pop_front();
        chk(m_tdata == it.d, $sformatf("R%0d receive byte", it.req), m_tdata, it.d);
        chk(m_tlast == it.last, "R8 receive tlast", m_tlast, it.last);
        chk(m_tuser == it.user, "R9 receive tuser", m_tuser, it.user);
      end
    end
  end

  task automatic drain();
    int t;
    t = 0;
    while ((tx_q.size() != 0 || rx_q.size() != 0) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(tx_q.size() == 0 && rx_q.size() == 0, "R2 queues drained", tx_q.size() + rx_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    s_tvalid = 1'b0; s_tdata = '0; s_tlast = 1'b0;
    inj_on = 1'b0; inj_d = '0; inj_dv = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!gmii_tx_en, "R10 tx_en after reset", gmii_tx_en, 0);
    chk(!s_tready, "R10 tready after reset", s_tready, 0);
    chk(!m_tvalid, "R10 m_tvalid after reset", m_tvalid, 0);

    send_frame(14, 1);    // R3 smallest frame
    drain();
    // R7: with no frame offered, nothing is taken
    repeat (20) @(negedge clk);
    chk(!s_tready, "R7 tready while idle", s_tready, 0);
    send_frame(59, 2);    // R3
    send_frame(60, 3);    // R4 boundary, R6 back to back
    send_frame(61, 4);    // R4
    drain();
    send_frame(200, 5);   // R4
    send_frame(1514, 6);  // R4 largest frame
    drain();
    repeat (30) @(negedge clk);
    inject(20, 7, 1'b1);  // R9 corrupted checksum
    inject(64, 8, 1'b0);  // R9 good checksum
    drain();
    finish_run();
  end

endmodule